// File: doc/BRIEF.md
# Configurable Audio Serial Frame Generator

This block turns parallel audio samples into a continuous serial frame made of a bit clock, a word-select line and one serial data line. The frame length is set by configuration, up to `FRAME_MAX` bits. The block places a 16-bit left sample and a 16-bit right sample at bit offsets that are set independently. It can also insert two 16-bit codec control words, and each of those has its own offset and its own enable. Every field goes out MSB first, starting at its programmed bit. A bit that no field covers is sent as zero. When fields overlap, a fixed priority decides which field wins.

The bit clock rate is set by a half-period strobe from outside the block. Each strobe toggles the serial clock. A configuration bit chooses whether data is launched on the rising or the falling serial-clock edge. Word-select has two forms: a level that marks the first half of the frame, or a one-bit pulse at frame bit 0. A polarity bit can invert either form.

Frames run without stopping, whether or not transmission is enabled. At each frame boundary the block does three things:
- it takes a sample pair through a valid/ready handshake,
- it reports an underrun when no pair is offered,
- it latches the control words for the frame that is starting.

An optional MSB inversion converts offset-binary samples to two's complement. This inversion also applies to the zeros sent on idle channels.

Top module: `afs_frame_gen`

## Requirements
- R1: While `rst` is high, `sck_o`, `sd_o`, `ws_o`, `smp_ready` and `underrun` are all 0. This holds even if `half_stb` is high. Until the first launch edge, `sd_o` and `ws_o` stay 0. The first launch edge after reset begins frame bit 0.
- R2: Each clock cycle with `half_stb`=1 toggles `sck_o`, and a cycle without it holds `sck_o`. A launch edge is a transition of `sck_o` to 1 when `cfg_launch_rise`=1, or to 0 when `cfg_launch_rise`=0. `sd_o` and `ws_o` change only in the cycle that follows a launch edge.
- R3: A frame has `cfg_frame_last`+1 bits, numbered 0 to `cfg_frame_last`, one bit per launch edge. Frames follow one another without a gap, including while `tx_en` is 0.
- R4: The left sample is sent MSB first on frame bits `cfg_left_pos` to `cfg_left_pos`+15, and the right sample on bits `cfg_right_pos` to `cfg_right_pos`+15. Any bit past the end of the frame is dropped. A bit that no enabled field covers is 0.
- R5: Control word 1 (`cw1_word`) is sent MSB first from bit `cfg_cw1_pos`, but only when `cfg_cw1_en` is 1. Control word 2 (`cw2_word`) is sent the same way from bit `cfg_cw2_pos` when `cfg_cw2_en` is 1. Where fields overlap, the priority is left, then right, then word 1, then word 2.
- R6: With `cfg_ws_pulse`=0, word-select is 1 on bits 0 to (`cfg_frame_last`+1)/2−1 and 0 on the rest of the frame. With `cfg_ws_pulse`=1, it is 1 only on bit 0. `cfg_ws_inv`=1 inverts the line in both forms.
- R7: At a frame start with `tx_en`=1 and `smp_valid`=1, `smp_ready` is 1 for exactly one cycle, and `smp_left`/`smp_right` from that cycle are sent in that frame. At no other time is `smp_ready` 1.
- R8: At a frame start with `tx_en`=1 and `smp_valid`=0, `underrun` is 1 for one cycle and both sample fields of that frame carry zero.
- R9: A frame that starts while `tx_en`=0 takes no sample (`smp_ready` stays 0) and raises no underrun. It sends zero for both samples and sends no control word.
- R10: With `cfg_sign_flip`=1, the MSB of both sample fields is inverted. This includes the zero values of idle or underrun frames. Control words are never inverted.
- R11: Control words and their enables are captured only at a frame start. A change to `cw1_word` or `cw2_word` in the middle of a frame first appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| half_stb | input | 1 | Half bit period strobe; each one toggles the serial clock |
| cfg_frame_last | input | CNT_W | Number of the last bit in the frame (frame length minus one) |
| cfg_left_pos | input | CNT_W | First bit of the left sample field |
| cfg_right_pos | input | CNT_W | First bit of the right sample field |
| cfg_cw1_pos | input | CNT_W | First bit of control word 1 |
| cfg_cw2_pos | input | CNT_W | First bit of control word 2 |
| cfg_cw1_en | input | 1 | Enables control word 1 |
| cfg_cw2_en | input | 1 | Enables control word 2 |
| cfg_ws_inv | input | 1 | Inverts word-select |
| cfg_ws_pulse | input | 1 | Selects the one-bit pulse form of word-select |
| cfg_launch_rise | input | 1 | 1: launch on the rising serial-clock edge, 0: on the falling edge |
| cfg_sign_flip | input | 1 | Inverts the MSB of both sample fields |
| tx_en | input | 1 | Transmit enable |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | 16 | Left sample |
| smp_right | input | 16 | Right sample |
| smp_ready | output | 1 | Sample pair taken in this cycle |
| cw1_word | input | 16 | Control word 1 |
| cw2_word | input | 16 | Control word 2 |
| underrun | output | 1 | No sample pair was offered at a frame start |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data |

## Verification
The frame boundary is the single cycle in which three things coincide: the sample handshake or the underrun report, the capture of the control words, and the bit counter wrapping to zero. The bench provokes this coincidence in three ways:
- It keeps a sample pair on offer across frames.
- It withholds samples while transmission is enabled.
- It rewrites control word 1 in the middle of a frame, before that word's field has begun.

For each case the bench records which serial bit each handshake or underrun pulse came just before, and checks that the pulse sits on bit 0 of each frame. It then checks that the old word fills the current frame and the new word fills only the frame after.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int SMP_W = 16;
  localparam int NCW   = 2;

  // true when frame bit k lies inside a field that starts at pos
  function automatic logic in_field(input int unsigned k, input int unsigned pos);
    return (k >= pos) && (k < pos + SMP_W);
  endfunction

  // bit of word w carried by frame bit k, MSB first from pos
  function automatic logic field_bit(input logic [SMP_W-1:0] w,
                                     input int unsigned k, input int unsigned pos);
    logic [SMP_W-1:0] sh;
    sh = w << (k - pos);
    return sh[SMP_W-1];
  endfunction

  // word-select level for frame bit k
  function automatic logic ws_level(input int unsigned k, input int unsigned last,
                                    input logic pulse, input logic inv);
    logic raw;
    if (pulse) raw = (k == 0);
    else       raw = (k < ((last + 1) >> 1));
    return raw ^ inv;
  endfunction

  function automatic logic [SMP_W-1:0] flip_msb(input logic [SMP_W-1:0] w, input logic en);
    return w ^ {en, {(SMP_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/afs_bitclk.sv
module afs_bitclk (
  input  logic clk,
  input  logic rst,
  input  logic half_stb,
  input  logic launch_rise,
  output logic sck_o,
  output logic launch
);
  logic sck_q;

  // a launch edge is the toggle that lands on the selected level
  assign launch = half_stb && !rst && ((~sck_q) == launch_rise);
  assign sck_o  = sck_q;

  always_ff @(posedge clk) begin
    if (rst)           sck_q <= 1'b0;
    else if (half_stb) sck_q <= ~sck_q;
  end
endmodule

// File: rtl/afs_seq.sv
module afs_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] frame_last,
  output logic [CNT_W-1:0] bit_idx,
  output logic             started,
  output logic             frame_start
);
  logic [CNT_W-1:0] idx_q;
  logic             started_q;

  assign frame_start = launch && (!started_q || (idx_q == frame_last));
  assign bit_idx     = idx_q;
  assign started     = started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      started_q <= 1'b0;
    end else if (launch) begin
      started_q <= 1'b1;
      idx_q     <= frame_start ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/afs_hold.sv
module afs_hold
  import afs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      tx_en,
  input  logic                      smp_valid,
  input  logic [SMP_W-1:0]          smp_left,
  input  logic [SMP_W-1:0]          smp_right,
  input  logic                      sign_flip,
  input  logic [NCW-1:0]            cw_en,
  input  logic [NCW-1:0][SMP_W-1:0] cw_word,
  output logic [SMP_W-1:0]          left_q,
  output logic [SMP_W-1:0]          right_q,
  output logic [NCW-1:0][SMP_W-1:0] cw_q,
  output logic [NCW-1:0]            cw_on,
  output logic                      smp_take,
  output logic                      underrun
);
  logic [SMP_W-1:0] left_nx, right_nx;

  assign smp_take = frame_start && tx_en && smp_valid;
  assign underrun = frame_start && tx_en && !smp_valid;
  assign left_nx  = flip_msb(smp_take ? smp_left  : '0, sign_flip);
  assign right_nx = flip_msb(smp_take ? smp_right : '0, sign_flip);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (frame_start) begin
      left_q  <= left_nx;
      right_q <= right_nx;
    end
  end

  for (genvar g = 0; g < NCW; g++) begin : g_cw
    always_ff @(posedge clk) begin
      if (rst) begin
        cw_q[g]  <= '0;
        cw_on[g] <= 1'b0;
      end else if (frame_start) begin
        cw_q[g]  <= cw_word[g];
        cw_on[g] <= cw_en[g] && tx_en;
      end
    end
  end
endmodule

// File: rtl/afs_serial.sv
module afs_serial
  import afs_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0]          bit_idx,
  input  logic                      started,
  input  logic [CNT_W-1:0]          frame_last,
  input  logic [CNT_W-1:0]          left_pos,
  input  logic [CNT_W-1:0]          right_pos,
  input  logic [NCW-1:0][CNT_W-1:0] cw_pos,
  input  logic [NCW-1:0]            cw_on,
  input  logic [SMP_W-1:0]          left_q,
  input  logic [SMP_W-1:0]          right_q,
  input  logic [NCW-1:0][SMP_W-1:0] cw_q,
  input  logic                      ws_pulse,
  input  logic                      ws_inv,
  output logic                      sd,
  output logic                      ws
);
  logic [31:0] k;
  logic [NCW:0] chain;
  logic sd_raw;

  assign k = 32'(bit_idx);
  assign chain[NCW] = 1'b0;

  // lower-numbered control word wins
  for (genvar g = 0; g < NCW; g++) begin : g_pick
    assign chain[g] = (cw_on[g] && in_field(k, 32'(cw_pos[g])))
                      ? field_bit(cw_q[g], k, 32'(cw_pos[g])) : chain[g+1];
  end

  always_comb begin
    if (in_field(k, 32'(left_pos)))       sd_raw = field_bit(left_q, k, 32'(left_pos));
    else if (in_field(k, 32'(right_pos))) sd_raw = field_bit(right_q, k, 32'(right_pos));
    else                                  sd_raw = chain[0];
  end

  assign sd = started && sd_raw;
  assign ws = started && ws_level(k, 32'(frame_last), ws_pulse, ws_inv);
endmodule

// File: rtl/afs_frame_gen.sv
module afs_frame_gen
  import afs_pkg::*;
#(
  parameter int FRAME_MAX = 64,
  localparam int CNT_W    = $clog2(FRAME_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_stb,
  input  logic [CNT_W-1:0] cfg_frame_last,
  input  logic [CNT_W-1:0] cfg_left_pos,
  input  logic [CNT_W-1:0] cfg_right_pos,
  input  logic [CNT_W-1:0] cfg_cw1_pos,
  input  logic [CNT_W-1:0] cfg_cw2_pos,
  input  logic             cfg_cw1_en,
  input  logic             cfg_cw2_en,
  input  logic             cfg_ws_inv,
  input  logic             cfg_ws_pulse,
  input  logic             cfg_launch_rise,
  input  logic             cfg_sign_flip,
  input  logic             tx_en,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] cw1_word,
  input  logic [SMP_W-1:0] cw2_word,
  output logic             underrun,
  output logic             sck_o,
  output logic             ws_o,
  output logic             sd_o
);
  // internal events, named for the checker
  logic                      launch_w;
  logic                      frame_start_w;
  logic                      started_w;
  logic [CNT_W-1:0]          bit_idx_w;
  logic [SMP_W-1:0]          left_w, right_w;
  logic [NCW-1:0][SMP_W-1:0] cw_w;
  logic [NCW-1:0]            cw_on_w;

  afs_bitclk u_bitclk (
    .clk(clk), .rst(rst), .half_stb(half_stb), .launch_rise(cfg_launch_rise),
    .sck_o(sck_o), .launch(launch_w)
  );

  afs_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch_w), .frame_last(cfg_frame_last),
    .bit_idx(bit_idx_w), .started(started_w), .frame_start(frame_start_w)
  );

  afs_hold u_hold (
    .clk(clk), .rst(rst), .frame_start(frame_start_w), .tx_en(tx_en),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .sign_flip(cfg_sign_flip),
    .cw_en({cfg_cw2_en, cfg_cw1_en}), .cw_word({cw2_word, cw1_word}),
    .left_q(left_w), .right_q(right_w), .cw_q(cw_w), .cw_on(cw_on_w),
    .smp_take(smp_ready), .underrun(underrun)
  );

  afs_serial #(.CNT_W(CNT_W)) u_serial (
    .bit_idx(bit_idx_w), .started(started_w), .frame_last(cfg_frame_last),
    .left_pos(cfg_left_pos), .right_pos(cfg_right_pos),
    .cw_pos({cfg_cw2_pos, cfg_cw1_pos}), .cw_on(cw_on_w),
    .left_q(left_w), .right_q(right_w), .cw_q(cw_w),
    .ws_pulse(cfg_ws_pulse), .ws_inv(cfg_ws_inv),
    .sd(sd_o), .ws(ws_o)
  );
endmodule

// File: rtl/afs_chk.sv
module afs_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             half_stb,
  input logic             sck_o,
  input logic             sd_o,
  input logic             ws_o,
  input logic             tx_en,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             underrun,
  input logic             launch_w,
  input logic             started_w,
  input logic [CNT_W-1:0] bit_idx_w,
  input logic [CNT_W-1:0] cfg_frame_last,
  input logic             cfg_ws_pulse,
  input logic             cfg_ws_inv
);
  // R2
  sck_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    half_stb |=> (sck_o != $past(sck_o)));
  // R2
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_stb |=> $stable(sck_o));
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !launch_w |=> ($stable(sd_o) && $stable(ws_o)));
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_idx_w <= cfg_frame_last);
  // R6
  ws_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (started_w && cfg_ws_pulse && (bit_idx_w != '0)) |-> (ws_o == cfg_ws_inv));
  // R7
  take_chk: assert property (@(posedge clk) disable iff (rst)
    smp_ready |-> (smp_valid && tx_en));
  // R8
  underrun_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (!smp_valid && tx_en && !smp_ready));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (!smp_ready && !underrun));
endmodule

bind afs_frame_gen afs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .half_stb(half_stb), .sck_o(sck_o), .sd_o(sd_o), .ws_o(ws_o),
  .tx_en(tx_en), .smp_valid(smp_valid), .smp_ready(smp_ready), .underrun(underrun),
  .launch_w(launch_w), .started_w(started_w), .bit_idx_w(bit_idx_w),
  .cfg_frame_last(cfg_frame_last), .cfg_ws_pulse(cfg_ws_pulse), .cfg_ws_inv(cfg_ws_inv)
);

// File: tb/test_afs_frame_gen.sv
module test_afs_frame_gen;
  typedef struct packed {
    logic [5:0]  last, lpos, rpos, c1pos, c2pos;
    logic        c1en, c2en, inv, rise, pulse, flip;
    logic [15:0] l, r, c1, c2;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{6'd63, 6'd0,  6'd32, 6'd16, 6'd48, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
      16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F},
    '{6'd31, 6'd0,  6'd16, 6'd8,  6'd24, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
      16'h7FFF, 16'h8001, 16'h1111, 16'h2222},
    '{6'd47, 6'd4,  6'd12, 6'd20, 6'd40, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
      16'hFFFF, 16'h0000, 16'h5555, 16'hFFFF},
    '{6'd63, 6'd48, 6'd16, 6'd0,  6'd32, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
      16'h0001, 16'h8000, 16'hC3C3, 16'h9999}
  };

  logic clk = 1'b0;
  logic rst, half_stb;
  logic [5:0] cfg_frame_last, cfg_left_pos, cfg_right_pos, cfg_cw1_pos, cfg_cw2_pos;
  logic cfg_cw1_en, cfg_cw2_en, cfg_ws_inv, cfg_ws_pulse, cfg_launch_rise, cfg_sign_flip;
  logic tx_en, smp_valid, smp_ready, underrun, sck_o, ws_o, sd_o;
  logic [15:0] smp_left, smp_right, cw1_word, cw2_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int glitches;
  logic sd_log [256];
  logic ws_log [256];
  logic rdy_log [256];
  logic und_log [256];

  always #5 clk = ~clk;

  afs_frame_gen i_afs_frame_gen (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] put(input logic [63:0] f, input logic [15:0] w,
                                      input int pos, input int len);
    logic [63:0] o = f;
    for (int j = 0; j < 16; j++)
      if (pos + j < len) o[pos + j] = w[15 - j];
    return o;
  endfunction

  function automatic logic [63:0] exp_sd(input vec_t v, input logic tx, input logic valid,
                                         input logic [15:0] c1);
    int len = int'(v.last) + 1;
    logic [15:0] l = (tx && valid) ? v.l : 16'h0;
    logic [15:0] r = (tx && valid) ? v.r : 16'h0;
    logic [63:0] f = '0;
    if (v.flip) begin l[15] = ~l[15]; r[15] = ~r[15]; end
    if (tx && v.c2en) f = put(f, v.c2, int'(v.c2pos), len);
    if (tx && v.c1en) f = put(f, c1, int'(v.c1pos), len);
    f = put(f, r, int'(v.rpos), len);
    f = put(f, l, int'(v.lpos), len);
    return f;
  endfunction

  function automatic logic [63:0] exp_ws(input vec_t v);
    int len = int'(v.last) + 1;
    logic [63:0] f = '0;
    for (int b = 0; b < len; b++)
      f[b] = (v.pulse ? (b == 0) : (b < len / 2)) ^ v.inv;
    return f;
  endfunction

  task automatic apply(input vec_t v, input logic tx, input logic valid);
    rst = 1'b1; half_stb = 1'b0;
    cfg_frame_last = v.last; cfg_left_pos = v.lpos; cfg_right_pos = v.rpos;
    cfg_cw1_pos = v.c1pos; cfg_cw2_pos = v.c2pos; cfg_cw1_en = v.c1en; cfg_cw2_en = v.c2en;
    cfg_ws_inv = v.inv; cfg_launch_rise = v.rise; cfg_ws_pulse = v.pulse; cfg_sign_flip = v.flip;
    smp_left = v.l; smp_right = v.r; cw1_word = v.c1; cw2_word = v.c2;
    tx_en = tx; smp_valid = valid;
    repeat (2) @(negedge clk);
    rst = 1'b0; half_stb = 1'b1;
  endtask

  task automatic observe(input int nbits, input int chg_at, input logic [15:0] chg_val);
    logic prev_sck = 1'b0, last_sd = 1'b0, last_ws = 1'b0;
    bit rdy_seen = 0, und_seen = 0;
    int cap = 0, guard = 0;
    glitches = 0;
    while (cap < nbits && guard < nbits * 4 + 16) begin
      #1;
      if (smp_ready) rdy_seen = 1;
      if (underrun)  und_seen = 1;
      if (sck_o == cfg_launch_rise && prev_sck != cfg_launch_rise) begin
        sd_log[cap] = sd_o; ws_log[cap] = ws_o;
        rdy_log[cap] = rdy_seen; und_log[cap] = und_seen;
        rdy_seen = 0; und_seen = 0;
        last_sd = sd_o; last_ws = ws_o;
        if (cap == chg_at) cw1_word = chg_val;
        cap++;
      end else if (sd_o !== last_sd || ws_o !== last_ws) begin
        glitches++;
      end
      prev_sck = sck_o;
      guard++;
      @(negedge clk);
    end
    chk(cap == nbits, "R3", "bits observed", 64'(cap), 64'(nbits));
  endtask

  task automatic check_frame(input vec_t v, input int f, input logic tx, input logic valid,
                             input logic [15:0] c1, input string tag);
    int len = int'(v.last) + 1;
    logic [63:0] a_sd = '0, a_ws = '0, a_rdy = '0, a_und = '0;
    for (int b = 0; b < len; b++) begin
      a_sd[b]  = sd_log[f * len + b];
      a_ws[b]  = ws_log[f * len + b];
      a_rdy[b] = rdy_log[f * len + b];
      a_und[b] = und_log[f * len + b];
    end
    chk(a_sd === exp_sd(v, tx, valid, c1), tag, "serial data frame", a_sd, exp_sd(v, tx, valid, c1));
    chk(a_ws === exp_ws(v), "R6/R3", "word-select frame", a_ws, exp_ws(v));
    chk(a_rdy === ((tx && valid) ? 64'h1 : 64'h0), "R7/R9", "ready at frame start",
        a_rdy, (tx && valid) ? 64'h1 : 64'h0);
    chk(a_und === ((tx && !valid) ? 64'h1 : 64'h0), "R8", "underrun at frame start",
        a_und, (tx && !valid) ? 64'h1 : 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic s_sck, s_sd, s_ws;
    // R1: reset holds every output low, even with the strobe running
    apply(VECS[0], 1'b1, 1'b1);
    rst = 1'b1; half_stb = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk({sck_o, sd_o, ws_o, smp_ready, underrun} === 5'b0, "R1", "outputs in reset",
        64'({sck_o, sd_o, ws_o, smp_ready, underrun}), 64'h0);

    // table walk: R4 R5 R6 R10 under several layouts
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      apply(v, 1'b1, 1'b1);
      observe(2 * (int'(v.last) + 1), -1, 16'h0);
      chk(glitches == 0, "R2", "line changed off launch edge", 64'(glitches), 64'h0);
      for (int f = 0; f < 2; f++) check_frame(v, f, 1'b1, 1'b1, v.c1, "R4/R5/R10");
    end

    // R8 R10: underrun sends flipped zeros
    v = VECS[0]; v.flip = 1'b1;
    apply(v, 1'b1, 1'b0);
    observe(int'(v.last) + 1, -1, 16'h0);
    check_frame(v, 0, 1'b1, 1'b0, v.c1, "R8/R10");

    // R9 R3: transmit off, frames continue, only flipped zeros go out
    v = VECS[3];
    apply(v, 1'b0, 1'b1);
    observe(2 * (int'(v.last) + 1), -1, 16'h0);
    for (int f = 0; f < 2; f++) check_frame(v, f, 1'b0, 1'b1, v.c1, "R9");

    // R11: control word rewritten mid frame reaches only the next frame
    v = VECS[0];
    apply(v, 1'b1, 1'b1);
    observe(2 * (int'(v.last) + 1), 10, 16'h1111);
    check_frame(v, 0, 1'b1, 1'b1, 16'hBEEF, "R11");
    check_frame(v, 1, 1'b1, 1'b1, 16'h1111, "R11");

    // R2: no strobe, no serial clock movement and no data change
    half_stb = 1'b0;
    @(negedge clk); #1;
    s_sck = sck_o; s_sd = sd_o; s_ws = ws_o;
    repeat (4) @(negedge clk);
    #1;
    chk({sck_o, sd_o, ws_o} === {s_sck, s_sd, s_ws}, "R2", "hold without strobe",
        64'({sck_o, sd_o, ws_o}), 64'({s_sck, s_sd, s_ws}));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule